// File: doc/BRIEF.md
# Key-Locked 64-bit Watchdog Timer

This block is a bus-mapped watchdog built on a 64-bit up-counter that is compared with a 64-bit period value. Software first sets it up with the block disarmed. It enables continuous counting in the timer control register, selects watchdog mode and releases both counter halves in the global control register, and loads the counter and period. It then arms the watchdog by writing two keys in turn to the key field of the watchdog control register. Once armed, the block ignores every configuration write. The only thing software can still do is write keys, and a correct key pair clears the counter.

When the counter reaches the period, the block emits a one-clock reset pulse, raises a sticky timeout flag, and begins counting again from zero. Software cannot disarm the watchdog. Only the block's hardware reset returns it to the disarmed, writable state.

The register bus is a single-cycle 32-bit interface with word addresses. A write takes effect on the clock edge where `bus_en` and `bus_we` are both high. Read data is a combinational function of `bus_addr`.

Top module: `keyed_wdog`

## Requirements
- R1: After reset every register reads zero, the block is disarmed and writable, and `wd_rst_pulse` and `wd_flag` are low.
- R2: While disarmed, writes at word offsets 0 to 5 load, in order, counter low, counter high, period low, period high, timer control and global control, and each reads back as written. At offset 6, bit 14 is the enable bit and reads back as written, bit 15 reads as the timeout flag, and the key field in bits 31:16 always reads as zero.
- R3: A write to offset 6 whose key is 0xA5C6 and whose bit 14 is 1 moves the block from disarmed to pre-armed. A following key 0xDA7E moves it to armed. If the 0xA5C6 write has bit 14 at 0, the block stays disarmed and writable.
- R4: From pre-armed onward, writes to offsets 0 to 5 and to the enable bit are ignored.
- R5: The counter adds one on each clock only when all of these hold: the block is armed (or mid-service), timer control bits 7:6 equal 2, global control bits 3:2 equal 2, and global control bits 1:0 equal 3. Otherwise it holds its value. A carry passes from the low half into the high half.
- R6: The timeout compare uses all 64 bits. On the clock edge where a counting counter equals the period, the counter returns to zero, `wd_rst_pulse` goes high for exactly one cycle and `wd_flag` is set. Counting then continues, so the next timeout follows period+1 clocks later.
- R7: While armed, key 0xA5C6 followed by key 0xDA7E clears the counter on the edge of the second write. Any other key value, or 0xDA7E without a preceding 0xA5C6, leaves the state and the counter unchanged.
- R8: Writing 1 to bit 15 of offset 6 clears the timeout flag in any state. Writing 0 to that bit leaves the flag as it is.
- R9: Once armed, no register write can stop counting or timeouts, and the enable bit keeps reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; the only way to disarm |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wd_rst_pulse | output | 1 | One-cycle timeout reset pulse |
| wd_flag | output | 1 | Sticky timeout flag |

## Verification
The bench counts clocks from the arming or servicing write to the reset pulse. A design that counts in the pre-armed state, or that compares the period one cycle late, lands one or more clocks away from period+1. The period is set to a high half of 1 with a low half near the 32-bit boundary. A design that compares only the low word would then fire early, and a design with a broken carry would leave the high half at zero. Keys out of order, unknown keys, an arming write with the enable bit clear, and attempts to rewrite the period or disarm after locking are each followed by a readback or a pulse measurement. These expose a lock that opens early, a service that clears without the full pair, or a watchdog that software can switch off.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   typedef enum logic [1:0] {
      WD_OFF = 2'd0,
      WD_PRE = 2'd1,
      WD_RUN = 2'd2,
      WD_SVC = 2'd3
   } wd_state_e;

   localparam int unsigned OFS_CNT_LO = 0;
   localparam int unsigned OFS_PRD_LO = 2;
   localparam int unsigned OFS_TCTL   = 4;
   localparam int unsigned OFS_GCTL   = 5;
   localparam int unsigned OFS_WCTL   = 6;

   localparam logic [1:0] TMODE_CONT = 2'd2;
   localparam logic [1:0] GMODE_WDOG = 2'd2;
   localparam int unsigned ENA_BIT   = 14;
   localparam int unsigned FLAG_BIT  = 15;
endpackage

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm
   import kwd_pkg::*;
#(
   parameter int KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6,
   parameter logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key,
   input  logic             ena_req,
   output wd_state_e        state,
   output logic             locked,
   output logic             svc_done
);
   wd_state_e state_d;

   always_comb begin
      state_d  = state;
      svc_done = 1'b0;
      if (key_wr) begin
         case (state)
            WD_OFF: if (key == KEY_FIRST && ena_req) state_d = WD_PRE;
            WD_PRE: if (key == KEY_SECOND) state_d = WD_RUN;
            WD_RUN: if (key == KEY_FIRST) state_d = WD_SVC;
            WD_SVC: if (key == KEY_SECOND) begin
               state_d  = WD_RUN;
               svc_done = 1'b1;
            end
            default: state_d = WD_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= WD_OFF;
      else        state <= state_d;
   end

   assign locked = (state != WD_OFF);

   p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);
   p_arm_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_OFF) |=> (state == WD_OFF || state == WD_PRE));
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32,
   localparam int HALVES = CNT_W / BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALVES-1:0] ld_en,
   input  logic [BUS_W-1:0]  ld_data,
   input  logic              run,
   input  logic              clr,
   input  logic [CNT_W-1:0]  prd,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              hit,
   output logic              pulse_q
);
   logic [CNT_W-1:0] cnt_d;

   generate
      if (CNT_W % BUS_W != 0) begin : g_bad_split
         $error("counter width must be a whole number of bus words");
      end
   endgenerate

   assign hit = run && (cnt_q == prd);

   always_comb begin
      cnt_d = cnt_q;
      if (clr || hit) cnt_d = '0;
      else if (run)   cnt_d = cnt_q + 1'b1;
      for (int h = 0; h < HALVES; h++) begin
         if (ld_en[h]) cnt_d[h*BUS_W +: BUS_W] = ld_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         pulse_q <= hit;
      end
   end

   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && !hit && ld_en == '0) |=> cnt_q == $past(cnt_q) + 1'b1);
   p_service_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ld_en == '0) |=> cnt_q == '0);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import kwd_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int CNT_W  = 64,
   parameter int ADDR_W = 3,
   parameter int KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6,
   parameter logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              wd_rst_pulse,
   output logic              wd_flag
);
   localparam int HALVES  = CNT_W / BUS_W;
   localparam int KEY_LSB = BUS_W - KEY_W;

   generate
      if (HALVES != 2) begin : g_bad_width
         $error("register map holds exactly two halves per 64-bit value");
      end
      if (KEY_LSB <= int'(FLAG_BIT)) begin : g_bad_key
         $error("key field overlaps the flag and enable bits");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("seven registers need at least three address bits");
      end
   endgenerate

   wd_state_e         state;
   logic              locked, svc_done, hit;
   logic              wr, wr_cfg, key_wr;
   logic [CNT_W-1:0]  cnt, prd_q;
   logic [BUS_W-1:0]  tctl_q, gctl_q;
   logic              ena_q, flag_q;
   logic [HALVES-1:0] cnt_ld;
   logic              run;

   assign wr     = bus_en && bus_we;
   assign wr_cfg = wr && !locked;
   assign key_wr = wr && (bus_addr == ADDR_W'(OFS_WCTL));

   kwd_keyfsm #(.KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key      (bus_wdata[BUS_W-1:KEY_LSB]),
      .ena_req  (bus_wdata[ENA_BIT]),
      .state    (state),
      .locked   (locked),
      .svc_done (svc_done)
   );

   genvar h;
   generate
      for (h = 0; h < HALVES; h++) begin : g_half
         assign cnt_ld[h] = wr_cfg && (bus_addr == ADDR_W'(OFS_CNT_LO + h));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prd_q[h*BUS_W +: BUS_W] <= '0;
            else if (wr_cfg && bus_addr == ADDR_W'(OFS_PRD_LO + h))
               prd_q[h*BUS_W +: BUS_W] <= bus_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tctl_q <= '0;
         gctl_q <= '0;
         ena_q  <= 1'b0;
      end else if (wr_cfg) begin
         if (bus_addr == ADDR_W'(OFS_TCTL)) tctl_q <= bus_wdata;
         if (bus_addr == ADDR_W'(OFS_GCTL)) gctl_q <= bus_wdata;
         if (bus_addr == ADDR_W'(OFS_WCTL)) ena_q  <= bus_wdata[ENA_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= 1'b0;
      else if (hit)                        flag_q <= 1'b1;
      else if (key_wr && bus_wdata[FLAG_BIT]) flag_q <= 1'b0;
   end

   assign run = (state == WD_RUN || state == WD_SVC)
             && tctl_q[7:6] == TMODE_CONT
             && gctl_q[3:2] == GMODE_WDOG
             && gctl_q[1:0] == 2'b11;

   kwd_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (cnt_ld),
      .ld_data (bus_wdata),
      .run     (run),
      .clr     (svc_done),
      .prd     (prd_q),
      .cnt_q   (cnt),
      .hit     (hit),
      .pulse_q (wd_rst_pulse)
   );

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < HALVES; k++) begin
         if (bus_addr == ADDR_W'(OFS_CNT_LO + k)) bus_rdata = cnt[k*BUS_W +: BUS_W];
         if (bus_addr == ADDR_W'(OFS_PRD_LO + k)) bus_rdata = prd_q[k*BUS_W +: BUS_W];
      end
      if (bus_addr == ADDR_W'(OFS_TCTL)) bus_rdata = tctl_q;
      if (bus_addr == ADDR_W'(OFS_GCTL)) bus_rdata = gctl_q;
      if (bus_addr == ADDR_W'(OFS_WCTL)) begin
         bus_rdata[ENA_BIT]  = ena_q;
         bus_rdata[FLAG_BIT] = flag_q;
      end
   end

   assign wd_flag = flag_q;

   p_flag_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_pulse |-> wd_flag);
   p_prd_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(prd_q) && $stable(tctl_q) && $stable(gctl_q));
   p_ena_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_RUN) |=> ena_q);
endmodule

// File: tb/tb_keyed_wdog.sv
`timescale 1ns/1ps
module tb_keyed_wdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wd_rst_pulse, wd_flag;

   int vectors = 0;
   int misses  = 0;

   localparam logic [31:0] K1 = 32'hA5C6_0000;
   localparam logic [31:0] K2 = 32'hDA7E_0000;
   localparam logic [31:0] EN = 32'h0000_4000;

   always #4 clk = ~clk;

   keyed_wdog dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wd_rst_pulse(wd_rst_pulse), .wd_flag(wd_flag)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      bus_en = 1'b0; bus_we = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_addr = 3'(a); bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 3'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_pulse(input int limit, output int n, output bit seen);
      n = 0; seen = 1'b0;
      while (!seen && n < limit) begin
         @(negedge clk);
         n++;
         if (wd_rst_pulse) seen = 1'b1;
      end
   endtask

   task automatic bring_up(input logic [31:0] prd_lo, input logic [31:0] prd_hi,
                           input logic [31:0] cnt_lo, input logic [31:0] tmode);
      wr(4, 32'h0);
      wr(5, 32'h0);
      wr(5, 32'h0000_000B);
      wr(0, cnt_lo);
      wr(1, 32'h0);
      wr(2, prd_lo);
      wr(3, prd_hi);
      wr(4, tmode);
   endtask

   task automatic arm();
      wr(6, K1 | EN);
      wr(6, K2 | EN);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      for (int a = 0; a < 7; a++) begin
         rd(a, d);
         chk($sformatf("R1 reg %0d after reset", a), d, 0);
      end
      chk("R1 pulse after reset", wd_rst_pulse, 0);
      chk("R1 flag after reset", wd_flag, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      do_reset();
      for (int a = 0; a < 6; a++) begin
         wr(a, 32'h1357_0000 + 32'(a * 17));
         rd(a, d);
         chk($sformatf("R2 readback offset %0d", a), d, 32'h1357_0000 + 32'(a * 17));
      end
      wr(6, 32'h1234_4000);
      rd(6, d);
      chk("R2 key field reads zero, enable bit kept", d, 32'h0000_4000);
      do_reset();
      wr(6, K1);
      wr(2, 32'd7);
      rd(2, d);
      chk("R3 first key without enable keeps block writable", d, 7);
   endtask

   task automatic t_arm_lock();
      logic [31:0] d;
      do_reset();
      bring_up(32'd20, 0, 0, 32'h80);
      wr(6, K1 | EN);
      wr(2, 32'd99);
      rd(2, d);
      chk("R4 period write ignored in pre-armed", d, 20);
      wr(6, K2 | EN);
      rd(6, d);
      chk("R2 R3 control reads enable only once armed", d, 32'h0000_4000);
      wr(4, 32'h0);
      wr(5, 32'h0);
      wr(3, 32'h5);
      rd(4, d); chk("R4 timer control frozen", d, 32'h80);
      rd(5, d); chk("R4 global control frozen", d, 32'hB);
      rd(3, d); chk("R4 period high frozen", d, 0);
   endtask

   task automatic t_timeout();
      int n; bit seen;
      logic [31:0] d;
      do_reset();
      bring_up(32'd20, 0, 0, 32'h80);
      arm();
      wait_pulse(100, n, seen);
      chk("R6 first timeout after period+1 clocks", n, 21);
      rd(6, d);
      chk("R6 flag set at timeout", d[15], 1);
      rd(0, d);
      chk("R6 counter restarts at zero", d, 0);
      wait_pulse(100, n, seen);
      chk("R6 second timeout after period+1 clocks", n, 21);
      @(negedge clk);
      chk("R6 pulse lasts one cycle", wd_rst_pulse, 0);
      wr(6, 32'h0);
      chk("R8 writing zero keeps flag", wd_flag, 1);
      wr(6, 32'h0000_8000);
      chk("R8 write-one clears flag", wd_flag, 0);
   endtask

   task automatic t_service();
      int n; bit seen;
      logic [31:0] c1, c2;
      do_reset();
      bring_up(32'd20, 0, 0, 32'h80);
      arm();
      repeat (3) @(negedge clk);
      wr(6, 32'h1234_0000);
      rd(0, c1);
      wr(6, K2);
      rd(0, c2);
      chk("R7 lone second key does not clear", c2, c1 + 1);
      wr(6, K1);
      wr(6, 32'h5555_0000);
      rd(0, c1);
      wr(6, K2);
      rd(0, c2);
      chk("R7 full pair clears counter", c2, 0);
      repeat (8) @(negedge clk);
      wr(6, K1);
      wr(6, K2);
      wait_pulse(100, n, seen);
      chk("R7 timeout period+1 after service", n, 21);
   endtask

   task automatic t_mode();
      logic [31:0] d;
      do_reset();
      bring_up(32'd20, 0, 0, 32'h40);
      arm();
      repeat (10) @(negedge clk);
      rd(0, d);
      chk("R5 one-shot mode does not count", d, 0);
      do_reset();
      bring_up(32'd20, 0, 0, 32'h80);
      wr(5, 32'h0000_0009);
      arm();
      repeat (10) @(negedge clk);
      rd(0, d);
      chk("R5 high half held in reset does not count", d, 0);
   endtask

   task automatic t_wide();
      int n; bit seen;
      logic [31:0] d;
      do_reset();
      bring_up(32'hFFFF_FFF8, 32'd1, 32'hFFFF_FFF0, 32'h80);
      arm();
      wait_pulse(40, n, seen);
      chk("R6 no timeout on low-word match only", seen, 0);
      rd(1, d);
      chk("R5 carry into counter high half", d, 1);
   endtask

   task automatic t_nodisable();
      int n; bit seen;
      logic [31:0] d;
      do_reset();
      bring_up(32'd20, 0, 0, 32'h80);
      arm();
      wr(6, 32'h0);
      wr(6, K1);
      rd(6, d);
      chk("R9 enable bit still set", d[14], 1);
      wait_pulse(40, n, seen);
      chk("R9 timeout still occurs", seen, 1);
   endtask

   initial begin
      #1_000_000;
      misses++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      t_reset();
      t_regs();
      t_arm_lock();
      t_timeout();
      t_service();
      t_mode();
      t_wide();
      t_nodisable();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule